// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Buffer

This block is the sample store of a logic analyzer. An upstream stage presents a row, made of the channel word and an 8-bit relative timestamp, with a one-cycle store strobe whenever the channels change or the timestamp counter rolls over. After an arm pulse, rows go into a circular pre-trigger window whose size in rows is set at arm time. Each new row replaces the oldest one in that window. A trigger pulse switches the block to linear fill of every row above the window. When the last row of memory has been written, `full` rises and the block stops storing.

Once full, the block streams the capture out, oldest first. It starts with the oldest pre-trigger row that survived and sends only the pre-trigger rows that were actually written. Then it sends the post-trigger rows in arrival order. Every row carries a flag that marks it as pre- or post-trigger, and the last row is marked. The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the row, its flag and its last marker hold still. A row is consumed on each cycle where both are high, and the next row may follow in the very next cycle. The store strobe has no back-pressure: a row offered while the block is not capturing is dropped.

Top module: `capbuf_top`

## Requirements
- R1: A row {timestamp, data} is written only in a cycle where `in_valid` is high and the block is capturing (armed and not yet full). The row is read back unchanged.
- R2: Before the trigger, rows cycle through a window of P rows (P = the clamped `precap_rows`). Only the newest P pre-trigger rows survive.
- R3: P is sampled on `arm` and clamped: 0 gives 1, and any value above DEPTH-1 gives DEPTH-1.
- R4: A `trig` pulse during pre-trigger capture ends the window. A row stored in the trigger cycle is the first post-trigger row. Post-trigger rows fill exactly DEPTH-P rows.
- R5: `full` rises in the cycle after the last post-trigger row is stored. It stays high until the next `arm`, and stores offered while it is high are dropped.
- R6: Readout sends min(written pre rows, P) pre-trigger rows, oldest first, then the DEPTH-P post-trigger rows in arrival order. No other rows are sent.
- R7: `out_post` is 0 on pre-trigger rows and 1 on post-trigger rows. No pre-trigger row follows a post-trigger row.
- R8: `out_valid` is high only while `full` is high. When it is high and `out_ready` is low, `out_data`, `out_ts`, `out_post` and `out_last` stay unchanged into the next cycle.
- R9: `arm` clears `full` and `out_valid` by the next cycle and starts a fresh capture from an empty window.
- R10: `trig` has no effect while idle, after the trigger, or while full.
- R11: `out_last` is high only on the final row of a readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start-capture pulse; latches the window size |
| precap_rows | input | ADDR_W+1 | Requested pre-trigger window size in rows |
| in_valid | input | 1 | Store strobe (change event or timestamp rollover) |
| in_data | input | DATA_W | Channel word |
| in_ts | input | TS_W | Relative timestamp |
| trig | input | 1 | Trigger pulse |
| full | output | 1 | Capture complete, readout available |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Consumer accepts the row |
| out_data | output | DATA_W | Channel word of the output row |
| out_ts | output | TS_W | Timestamp of the output row |
| out_post | output | 1 | 1 = row stored after the trigger |
| out_last | output | 1 | Final row of the readout |

## Verification
Random captures vary the window size, the number of pre-trigger rows (fewer than, equal to and many times P), gaps between stores, whether a row comes with the trigger, and consumer stall patterns. The comparison of the read stream against a model separates correct wrap-start addressing from off-by-one or start-at-zero errors, and separates the partial-window case from the wrapped case. Directed cases cover the clamp ends (0 and oversize), a trigger before any pre row, stray triggers and stores while idle or full, and an arm in mid-readout.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_POST = 2'd2,
    PH_FULL = 2'd3
  } cap_phase_e;
endpackage

// File: rtl/capbuf_ram.sv
module capbuf_ram #(
  parameter int ROW_W = 16,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ROW_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [ROW_W-1:0] rdata
);
  logic [ROW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read: rdata holds when re is low
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/capbuf_wr_ctrl.sv
module capbuf_wr_ctrl
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW:0]   precap_req,
  input  logic          in_valid,
  input  logic          trig,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] pre_len,
  output logic [AW-1:0] pre_count,
  output logic [AW-1:0] oldest,
  output logic          full,
  output logic          fill_done
);
  localparam int            LAST_I  = DEPTH - 1;
  localparam logic [AW:0]   MAXPRE  = LAST_I[AW:0];
  localparam logic [AW-1:0] LAST_A  = LAST_I[AW-1:0];

  cap_phase_e    phase;
  logic [AW-1:0] pre_ptr;
  logic [AW-1:0] post_ptr;
  logic          wrapped;

  function automatic logic [AW-1:0] clamp_pre(input logic [AW:0] req);
    if (req == '0)         return AW'(1);
    else if (req > MAXPRE) return LAST_A;
    else                   return req[AW-1:0];
  endfunction

  always_comb begin
    we    = in_valid && !arm && (phase == PH_PRE || phase == PH_POST);
    waddr = post_ptr;
    if (phase == PH_PRE) waddr = trig ? pre_len : pre_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      pre_len   <= AW'(1);
      pre_ptr   <= '0;
      post_ptr  <= '0;
      wrapped   <= 1'b0;
      pre_count <= '0;
      oldest    <= '0;
      full      <= 1'b0;
      fill_done <= 1'b0;
    end else if (arm) begin
      phase     <= PH_PRE;
      pre_len   <= clamp_pre(precap_req);
      pre_ptr   <= '0;
      post_ptr  <= '0;
      wrapped   <= 1'b0;
      pre_count <= '0;
      oldest    <= '0;
      full      <= 1'b0;
      fill_done <= 1'b0;
    end else begin
      fill_done <= 1'b0;
      unique case (phase)
        PH_PRE: begin
          if (trig) begin
            pre_count <= wrapped ? pre_len : pre_ptr;
            oldest    <= wrapped ? pre_ptr : '0;
            if (in_valid) begin
              if (pre_len == LAST_A) begin
                phase     <= PH_FULL;
                full      <= 1'b1;
                fill_done <= 1'b1;
              end else begin
                post_ptr <= pre_len + AW'(1);
                phase    <= PH_POST;
              end
            end else begin
              post_ptr <= pre_len;
              phase    <= PH_POST;
            end
          end else if (in_valid) begin
            if (pre_ptr == pre_len - AW'(1)) begin
              pre_ptr <= '0;
              wrapped <= 1'b1;
            end else begin
              pre_ptr <= pre_ptr + AW'(1);
            end
          end
        end
        PH_POST: begin
          if (in_valid) begin
            if (post_ptr == LAST_A) begin
              phase     <= PH_FULL;
              full      <= 1'b1;
              fill_done <= 1'b1;
            end else begin
              post_ptr <= post_ptr + AW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/capbuf_rd_ctrl.sv
module capbuf_rd_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          start,
  input  logic [AW-1:0] pre_len,
  input  logic [AW-1:0] pre_count,
  input  logic [AW-1:0] oldest,
  input  logic          out_ready,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          out_valid,
  output logic          out_post,
  output logic          out_last
);
  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

  logic        busy;
  logic [AW:0] idx;
  logic [AW:0] total;
  logic [AW:0] plen_w, pcnt_w;
  logic [AW:0] wrap_sum;
  logic        in_pre;

  always_comb begin
    plen_w   = {1'b0, pre_len};
    pcnt_w   = {1'b0, pre_count};
    total    = pcnt_w + (DEPTH_V - plen_w);
    in_pre   = idx < pcnt_w;
    wrap_sum = {1'b0, oldest} + idx;
    if (wrap_sum >= plen_w) wrap_sum = wrap_sum - plen_w;
    if (in_pre) raddr = wrap_sum[AW-1:0];
    else        raddr = AW'(plen_w + idx - pcnt_w);
    re = busy && (idx < total) && (!out_valid || out_ready);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      busy      <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_post  <= 1'b0;
      out_last  <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (re) begin
      idx       <= idx + 1'b1;
      out_valid <= 1'b1;
      out_post  <= !in_pre;
      out_last  <= (idx == total - 1'b1);
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/capbuf_top.sv
module capbuf_top #(
  parameter int DATA_W = 8,
  parameter int TS_W   = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [ADDR_W:0]   precap_rows,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TS_W-1:0]   in_ts,
  input  logic              trig,
  output logic              full,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [TS_W-1:0]   out_ts,
  output logic              out_post,
  output logic              out_last
);
  localparam int ROW_W = DATA_W + TS_W;

  logic              we, re, fill_done;
  logic [ADDR_W-1:0] waddr, raddr, pre_len, pre_count, oldest;
  logic [ROW_W-1:0]  rdata;

  capbuf_wr_ctrl #(.DEPTH(DEPTH), .AW(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .precap_req(precap_rows),
    .in_valid(in_valid), .trig(trig), .we(we), .waddr(waddr),
    .pre_len(pre_len), .pre_count(pre_count), .oldest(oldest),
    .full(full), .fill_done(fill_done)
  );

  capbuf_ram #(.ROW_W(ROW_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata({in_ts, in_data}),
    .re(re), .raddr(raddr), .rdata(rdata)
  );

  capbuf_rd_ctrl #(.DEPTH(DEPTH), .AW(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start(fill_done),
    .pre_len(pre_len), .pre_count(pre_count), .oldest(oldest),
    .out_ready(out_ready), .re(re), .raddr(raddr),
    .out_valid(out_valid), .out_post(out_post), .out_last(out_last)
  );

  assign out_data = rdata[DATA_W-1:0];
  assign out_ts   = rdata[ROW_W-1:DATA_W];
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
  parameter int DATA_W = 8,
  parameter int TS_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              full,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [TS_W-1:0]   out_ts,
  input logic              out_post,
  input logic              out_last
);
  // R8
  valid_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> full);

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !arm) |=>
      (out_valid && $stable(out_data) && $stable(out_ts) &&
       $stable(out_post) && $stable(out_last)));

  // R9
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!full && !out_valid));

  // R5
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !arm) |=> full);

  // R7
  post_then_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_post && !out_last && !arm) |=>
      (!out_valid || out_post));

  // R11
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind capbuf_top capbuf_chk #(.DATA_W(DATA_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .full(full),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_ts(out_ts), .out_post(out_post), .out_last(out_last)
);

// File: tb/capbuf_top_bench.sv
module capbuf_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, TW = 8, DEPTH = 16, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, in_valid = 1'b0, trig = 1'b0, out_ready = 1'b0;
  logic [AW:0] precap_rows = '0;
  logic [DW-1:0] in_data = '0;
  logic [TW-1:0] in_ts = '0;
  logic full, out_valid, out_post, out_last;
  logic [DW-1:0] out_data;
  logic [TW-1:0] out_ts;

  int tests = 0, fails = 0;
  logic [15:0] pre_hist [64];
  logic [15:0] post_hist [64];
  int n_pre, n_post, eff;

  always #(CLK_PERIOD/2) clk = ~clk;

  capbuf_top #(.DATA_W(DW), .TS_W(TW), .DEPTH(DEPTH)) u_capbuf_top (
    .clk(clk), .rst_n(rst_n), .arm(arm), .precap_rows(precap_rows),
    .in_valid(in_valid), .in_data(in_data), .in_ts(in_ts), .trig(trig),
    .full(full), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ts(out_ts), .out_post(out_post), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clamp_model(input int req);
    if (req == 0) return 1;
    if (req > DEPTH - 1) return DEPTH - 1;
    return req;
  endfunction

  task automatic do_arm(input int req);
    @(negedge clk);
    arm = 1'b1; precap_rows = req[AW:0];
    @(negedge clk);
    arm = 1'b0;
    eff = clamp_model(req); n_pre = 0; n_post = 0;
  endtask

  task automatic idle_gap();
    int g = $urandom_range(0, 2);
    for (int i = 0; i < g; i++) @(negedge clk);
  endtask

  // one store; with_trig raises trig in the same cycle
  task automatic store(input bit with_trig, input bit post);
    logic [15:0] row = 16'($urandom);
    in_valid = 1'b1; trig = with_trig;
    {in_ts, in_data} = row;
    @(negedge clk);
    in_valid = 1'b0; trig = 1'b0;
    if (post) begin post_hist[n_post] = row; n_post++; end
    else begin pre_hist[n_pre] = row; n_pre++; end
  endtask

  task automatic fill(input int pre_rows, input bit trig_row, input bit stray);
    for (int i = 0; i < pre_rows; i++) begin store(1'b0, 1'b0); idle_gap(); end
    if (trig_row) store(1'b1, 1'b1);
    else begin trig = 1'b1; @(negedge clk); trig = 1'b0; end
    while (n_post < DEPTH - eff) begin
      if (n_post == DEPTH - eff - 1)
        chk(full == 1'b0, "R5 full early", full, 0);
      if (stray) begin trig = 1'b1; @(negedge clk); trig = 1'b0; end  // R10
      store(1'b0, 1'b1);
      idle_gap();
    end
    chk(full == 1'b1, "R5 full after last row", full, 1);
    // R5 stores while full are dropped, R10 trig ignored
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; trig = 1'b1; {in_ts, in_data} = 16'hDEAD;
      @(negedge clk);
    end
    in_valid = 1'b0; trig = 1'b0;
  endtask

  // read the whole stream, compare each row (R1 R2 R6 R7 R11), stall randomly (R8)
  task automatic drain(input int stall_pct);
    int kept = (n_pre < eff) ? n_pre : eff;
    int total = kept + (DEPTH - eff);
    int got = 0, spins = 0;
    logic [15:0] exp;
    bit exp_post;
    while (got < total && spins < 2000) begin
      out_ready = ($urandom_range(0, 99) >= stall_pct);
      if (out_valid && out_ready) begin
        if (got < kept) begin exp = pre_hist[n_pre - kept + got]; exp_post = 1'b0; end
        else begin exp = post_hist[got - kept]; exp_post = 1'b1; end
        chk({out_ts, out_data} == exp, "R6 row content/order", {out_ts, out_data}, exp);
        chk(out_post == exp_post, "R7 post flag", out_post, exp_post);
        chk(out_last == (got == total - 1), "R11 last marker", out_last, got == total - 1);
        chk(full == 1'b1, "R8 valid only when full", full, 1);
        got++;
      end
      @(negedge clk);
      spins++;
    end
    out_ready = 1'b1;
    chk(got == total, "R6 row count", got, total);
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 no extra rows", out_valid, 0);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full == 1'b0 && out_valid == 1'b0, "reset state", {full, out_valid}, 0);

    // R10 trig and stores while idle have no effect
    in_valid = 1'b1; trig = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0; trig = 1'b0;
    chk(full == 1'b0 && out_valid == 1'b0, "R10 idle trig ignored", full, 0);

    // R2 partial window: 2 of 4 rows written
    do_arm(4); fill(2, 1'b1, 1'b0); drain(0);
    // R2 wrapped window, stalls
    do_arm(4); fill(10, 1'b0, 1'b1); drain(50);
    // R4 trigger before any pre row
    do_arm(6); fill(0, 1'b1, 1'b0); drain(30);
    // R3 clamp low: 0 -> 1
    do_arm(0); fill(5, 1'b0, 1'b0); drain(0);
    // R3 clamp high: 31 -> 15, trigger row fills memory at once
    do_arm(31); fill(20, 1'b1, 1'b0); drain(20);
    // R3 exact limit
    do_arm(15); fill(15, 1'b0, 1'b0); drain(0);

    // R9 arm during readout
    do_arm(5); fill(7, 1'b1, 1'b0);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    arm = 1'b1; precap_rows = 5'd3;
    @(negedge clk);
    arm = 1'b0; out_ready = 1'b0;
    chk(full == 1'b0 && out_valid == 1'b0, "R9 arm clears", {full, out_valid}, 0);
    eff = 3; n_pre = 0; n_post = 0;
    fill(4, 1'b0, 1'b0); drain(10);

    // random captures (R1 R2 R4 R6 R7 R8)
    for (int k = 0; k < 25; k++) begin
      do_arm($urandom_range(0, 31));
      fill($urandom_range(0, 40), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      drain($urandom_range(0, 70));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule